// File: doc/BRIEF.md
# Register-Mapped Slave Block-Read Engine

This engine is the byte-level core of a two-wire slave device that holds an 8-bit register file. A bit-level front end passes it pulses for START (which includes repeated START) and STOP, each byte the master writes, and the master's acknowledge after each byte the slave returns. The engine decides whether the slave acknowledges. It keeps the register pointer, reads bytes from the register file through a synchronous port, and presents each byte to the front end for shifting.

A read starts with a write-addressed header that carries one byte. That byte is either a register address or a fixed-block command code. A repeated START and a read-addressed header follow. In a plain read, the slave returns bytes from consecutive addresses, beginning at the one written. For a fixed-block command, the slave first returns a byte count and then the block contents. In both cases the slave keeps sending for as long as the master acknowledges. The pointer never wraps past the top of the space, and reads outside the implemented registers return zero. A NACK from the master releases the bus.

Top module: `i2c_blkrd_engine`

## Requirements
- R1: The slave acknowledges the first header byte after a START only when it equals {DEV_ADDR, 0} (direction bit 0 means write). On any other byte it does not acknowledge, and it ignores all bytes until the next START.
- R2: The byte after an accepted write header is always acknowledged. It is followed by a repeated START and a byte equal to {DEV_ADDR, 1}, which is acknowledged and starts the read. A read header that arrives without a preceding command byte is not acknowledged.
- R3: For a command byte outside F2h..FDh, the returned bytes are the registers at that address, then at address+1, and so on. Each byte is fetched after the master acknowledges the byte before it.
- R4: For a command byte c in F2h..FDh, the first returned byte is the count BLK_LEN. After it come the registers starting at address (c − F2h) × BLK_LEN.
- R5: A byte whose address is above MAP_LAST is returned as 00h, and the register file is not strobed for it.
- R6: The pointer does not wrap from FFh to 00h. Once it passes FFh it stays in an out-of-space state, and every further byte is 00h.
- R7: When the master acknowledges more bytes than the count or the requested length, the slave keeps supplying successive bytes until a NACK.
- R8: After the master NACKs a returned byte, tx_en falls within one cycle and stays low until a new transaction reaches its data phase.
- R9: A STOP, or a START in any state other than waiting for the repeated START, aborts the transaction. tx_en falls, and the next header is treated as a fresh write header.
- R10: Each in-range byte uses exactly one single-cycle rf_rd strobe. Its data, rf_rdata, is taken the cycle after the strobe, before tx_en rises for that byte.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Pulse: START or repeated START seen |
| ev_stop | input | 1 | Pulse: STOP seen |
| rx_valid | input | 1 | Pulse: a byte from the master is complete |
| rx_byte | input | 8 | Byte received from the master |
| mack_valid | input | 1 | Pulse: master's acknowledge bit after a returned byte |
| mack_nack | input | 1 | With mack_valid: 1 = NACK, 0 = ACK |
| ack_out | output | 1 | Pulse one cycle after rx_valid: slave acknowledges that byte |
| tx_en | output | 1 | Slave owns SDA and tx_data holds the byte to shift |
| tx_data | output | 8 | Byte to return to the master |
| rf_rd | output | 1 | Register-file read strobe |
| rf_addr | output | 8 | Register-file read address |
| rf_rdata | input | 8 | Register-file data, valid the cycle after rf_rd |

## Verification
On every cycle, the assertions check four things. Each acknowledge follows a received byte. A NACK or STOP drops tx_en on the next cycle. The pointer never leaves its out-of-space state on its own and steps by exactly one. Strobes are single cycles, and zero bytes for unmapped addresses appear without a strobe. Only the bench's scenarios can show the rest: that the returned byte sequence is correct for plain and fixed-block reads, that the count prefix is right, that data continues past the count, that no wrap occurs near FFh, and that aborted or mis-addressed transactions are rejected.

// File: rtl/blkrd_pkg.sv
package blkrd_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = BYTE_W + 1;

    localparam logic [BYTE_W-1:0] FIXED_LO = 8'hF2;
    localparam logic [BYTE_W-1:0] FIXED_HI = 8'hFD;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_W,
        ST_CMD,
        ST_WAIT_RS,
        ST_ADDR_R,
        ST_SEND
    } eng_state_e;

    typedef struct packed {
        logic             use_cnt;
        logic [PTR_W-1:0] ptr;
    } fetch_req_t;

    function automatic logic is_fixed(input logic [BYTE_W-1:0] c);
        return (c >= FIXED_LO) && (c <= FIXED_HI);
    endfunction

    function automatic logic [PTR_W-1:0] fixed_base(input logic [BYTE_W-1:0] c,
                                                    input int len);
        int b;
        b = (int'(c) - int'(FIXED_LO)) * len;
        if (b > (1 << BYTE_W)) b = 1 << BYTE_W;
        return b[PTR_W-1:0];
    endfunction

endpackage

// File: rtl/blkrd_ptr.sv
module blkrd_ptr
    import blkrd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             inc,
    output logic [PTR_W-1:0] ptr
);

    logic [PTR_W-1:0] ptr_q;
    logic             oos;

    assign oos = ptr_q[PTR_W-1];
    assign ptr = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_val;
        end else if (inc && !oos) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    // R6: out-of-space state is sticky until a new command loads the pointer
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (oos && !load) |=> ptr_q[PTR_W-1]);

    // R3: an increment moves the pointer by exactly one
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && !oos) |=> (ptr_q == $past(ptr_q) + 1'b1));

endmodule

// File: rtl/blkrd_fetch.sv
module blkrd_fetch
    import blkrd_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MAP_LAST = 8'hBF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  fetch_req_t        req,
    input  logic [BYTE_W-1:0] cnt_val,
    input  logic              clear,
    output logic              rf_rd,
    output logic [BYTE_W-1:0] rf_addr,
    input  logic [BYTE_W-1:0] rf_rdata,
    output logic [BYTE_W-1:0] tx_data,
    output logic              ready
);

    logic in_map;
    logic pend_q;

    assign in_map  = !req.ptr[PTR_W-1] && (req.ptr[BYTE_W-1:0] <= MAP_LAST);
    assign rf_rd   = go && !req.use_cnt && in_map;
    assign rf_addr = req.ptr[BYTE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pend_q  <= 1'b0;
            ready   <= 1'b0;
            tx_data <= '0;
        end else begin
            if (go) begin
                if (req.use_cnt) begin
                    tx_data <= cnt_val;
                    ready   <= 1'b1;
                end else if (in_map) begin
                    pend_q  <= 1'b1;
                end else begin
                    tx_data <= '0;
                    ready   <= 1'b1;
                end
            end
            if (pend_q) begin
                tx_data <= rf_rdata;
                ready   <= 1'b1;
                pend_q  <= 1'b0;
            end
        end
    end

    // R10: the read strobe is a single-cycle pulse
    p_strobe_single_r10: assert property (@(posedge clk) disable iff (rst)
        rf_rd |=> !rf_rd);

    // R10: data is not presented in the cycle right after a strobe
    p_data_after_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        (rf_rd && !clear) |=> !ready);

    // R5: an unmapped byte is presented as zero with no strobe
    p_zero_unmapped_r5: assert property (@(posedge clk) disable iff (rst)
        (go && !req.use_cnt && !in_map && !clear) |=> (ready && tx_data == '0 && !$past(rf_rd)));

endmodule

// File: rtl/i2c_blkrd_engine.sv
module i2c_blkrd_engine
    import blkrd_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR = 7'h2C,
    parameter logic [BYTE_W-1:0] MAP_LAST = 8'hBF,
    parameter int                BLK_LEN  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              mack_valid,
    input  logic              mack_nack,
    output logic              ack_out,
    output logic              tx_en,
    output logic [BYTE_W-1:0] tx_data,
    output logic              rf_rd,
    output logic [BYTE_W-1:0] rf_addr,
    input  logic [BYTE_W-1:0] rf_rdata
);

    localparam logic [BYTE_W-1:0] HDR_W   = {DEV_ADDR, 1'b0};
    localparam logic [BYTE_W-1:0] HDR_R   = {DEV_ADDR, 1'b1};
    localparam logic [BYTE_W-1:0] CNT_VAL = BYTE_W'(BLK_LEN);

    eng_state_e       state;
    logic             cnt_q;
    logic             go_q;
    logic             ack_q;
    logic             bus_ev;
    logic             ptr_load;
    logic [PTR_W-1:0] ptr_load_val;
    logic             ptr_inc;
    logic [PTR_W-1:0] ptr;
    logic             fetch_clear;
    logic             ready;
    fetch_req_t       req;

    assign bus_ev = ev_start || ev_stop;

    always_ff @(posedge clk) begin
        ack_q <= 1'b0;
        go_q  <= 1'b0;
        if (rst) begin
            state <= ST_IDLE;
            cnt_q <= 1'b0;
        end else if (ev_stop) begin
            state <= ST_IDLE;
            cnt_q <= 1'b0;
        end else if (ev_start) begin
            if (state == ST_WAIT_RS) begin
                state <= ST_ADDR_R;
            end else begin
                state <= ST_ADDR_W;
                cnt_q <= 1'b0;
            end
        end else begin
            unique case (state)
                ST_ADDR_W: if (rx_valid) begin
                    if (rx_byte == HDR_W) begin
                        ack_q <= 1'b1;
                        state <= ST_CMD;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_CMD: if (rx_valid) begin
                    ack_q <= 1'b1;
                    cnt_q <= is_fixed(rx_byte);
                    state <= ST_WAIT_RS;
                end
                ST_ADDR_R: if (rx_valid) begin
                    if (rx_byte == HDR_R) begin
                        ack_q <= 1'b1;
                        go_q  <= 1'b1;
                        state <= ST_SEND;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_SEND: if (mack_valid) begin
                    if (mack_nack) begin
                        state <= ST_IDLE;
                    end else begin
                        go_q  <= 1'b1;
                        cnt_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign ptr_load     = (state == ST_CMD) && rx_valid && !bus_ev;
    assign ptr_load_val = is_fixed(rx_byte) ? fixed_base(rx_byte, BLK_LEN)
                                            : {1'b0, rx_byte};
    assign ptr_inc      = (state == ST_SEND) && mack_valid && !mack_nack && !cnt_q && !bus_ev;
    assign fetch_clear  = bus_ev || ((state == ST_SEND) && mack_valid);

    assign req.use_cnt = cnt_q;
    assign req.ptr     = ptr;

    blkrd_ptr u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (ptr_load_val),
        .inc      (ptr_inc),
        .ptr      (ptr)
    );

    blkrd_fetch #(
        .MAP_LAST (MAP_LAST)
    ) u_fetch (
        .clk      (clk),
        .rst      (rst),
        .go       (go_q),
        .req      (req),
        .cnt_val  (CNT_VAL),
        .clear    (fetch_clear),
        .rf_rd    (rf_rd),
        .rf_addr  (rf_addr),
        .rf_rdata (rf_rdata),
        .tx_data  (tx_data),
        .ready    (ready)
    );

    assign ack_out = ack_q;
    assign tx_en   = ready && (state == ST_SEND);

    // R1: an acknowledge only ever follows a received byte
    p_ack_after_rx_r1: assert property (@(posedge clk) disable iff (rst)
        ack_out |-> $past(rx_valid));

    // R2: the read header phase is only reached through the repeated START wait
    p_read_hdr_path_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(state == ST_ADDR_R)) |-> ($past(state) == ST_WAIT_RS));

    // R8: a NACK releases the data line on the next cycle
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_SEND) && mack_valid && mack_nack && !bus_ev) |=> !tx_en);

    // R9: a STOP leaves the engine quiet
    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> (!tx_en && !ack_out));

endmodule

// File: tb/i2c_blkrd_engine_bench.sv
`timescale 1ns/1ps
module i2c_blkrd_engine_bench;

    localparam logic [6:0] DEV      = 7'h2C;
    localparam int         MAPLAST  = 8'hBF;
    localparam int         BLEN     = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_start = 1'b0, ev_stop = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       mack_valid = 1'b0, mack_nack = 1'b0;
    logic       ack_out, tx_en, rf_rd;
    logic [7:0] tx_data, rf_addr, rf_rdata;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    bit quiet = 1'b1;

    always #2 clk = ~clk;

    i2c_blkrd_engine #(.DEV_ADDR(DEV), .MAP_LAST(8'(MAPLAST)), .BLK_LEN(BLEN)) u_i2c_blkrd_engine (
        .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .mack_valid(mack_valid), .mack_nack(mack_nack),
        .ack_out(ack_out), .tx_en(tx_en), .tx_data(tx_data),
        .rf_rd(rf_rd), .rf_addr(rf_addr), .rf_rdata(rf_rdata)
    );

    function automatic logic [7:0] rf_val(input int a);
        return 8'(a * 7 + 3) ^ 8'h5A;
    endfunction

    function automatic logic [7:0] exp_at(input int a);
        return (a <= MAPLAST) ? rf_val(a) : 8'h00;
    endfunction

    // register file model: garbage when not strobed
    always @(posedge clk) rf_rdata <= rf_rd ? rf_val(int'(rf_addr)) : 8'hEE;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // per-cycle reference comparison
    always @(negedge clk) begin
        if (!rst) begin
            if (rf_rd) begin
                strobes++;
                if (int'(rf_addr) > MAPLAST) begin
                    errors++; checks++;
                    $display("FAIL R5 strobe at addr actual %0h expected <= %0h", rf_addr, MAPLAST);
                end
            end
            if (quiet && tx_en) begin
                errors++; checks++;
                $display("FAIL R8 tx_en actual 1 expected 0");
            end
        end
    end

    task automatic do_start();
        @(negedge clk); ev_start = 1'b1;
        @(negedge clk); ev_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); ev_stop = 1'b1;
        @(negedge clk); ev_stop = 1'b0;
        quiet = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
        chk(ack_out == exp_ack, tag, ack_out, exp_ack);
    endtask

    task automatic get_byte(input logic [7:0] exp, input bit last, input string tag);
        bit seen;
        seen = 1'b0;
        quiet = 1'b0;
        for (int k = 0; k < 12; k++) begin
            if (tx_en) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        chk(seen, {tag, " tx_en"}, seen, 1);
        chk(tx_data == exp, tag, tx_data, exp);
        mack_valid = 1'b1; mack_nack = last;
        @(negedge clk); mack_valid = 1'b0; mack_nack = 1'b0;
        if (last) quiet = 1'b1;
    endtask

    task automatic read_tx(input logic [7:0] cmd, input int n, input string tag);
        logic [7:0] q[$];
        int want_strb;
        int s0;
        int base;
        want_strb = 0;
        if (cmd >= 8'hF2 && cmd <= 8'hFD) begin
            base = (int'(cmd) - 'hF2) * BLEN;
            q.push_back(8'(BLEN));
            for (int i = 0; i < n - 1; i++) begin
                q.push_back(exp_at(base + i));
                if (base + i <= MAPLAST) want_strb++;
            end
        end else begin
            for (int i = 0; i < n; i++) begin
                q.push_back(exp_at(int'(cmd) + i));
                if (int'(cmd) + i <= MAPLAST) want_strb++;
            end
        end
        do_start();
        send_byte({DEV, 1'b0}, 1'b1, "R1 write header");
        send_byte(cmd, 1'b1, "R2 command byte");
        do_start();
        send_byte({DEV, 1'b1}, 1'b1, "R2 read header");
        s0 = strobes;
        foreach (q[i]) get_byte(q[i], i == q.size() - 1, tag);
        chk(strobes - s0 == want_strb, "R10 strobe count", strobes - s0, want_strb);
        do_stop();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!tx_en && !ack_out && !rf_rd, "reset outputs", {tx_en, ack_out, rf_rd}, 0);

        // R1: wrong device address, then later bytes ignored
        do_start();
        send_byte({DEV ^ 7'h01, 1'b0}, 1'b0, "R1 wrong address");
        send_byte(8'h10, 1'b0, "R1 ignored after mismatch");
        do_stop();

        // R2: read header with no command first
        do_start();
        send_byte({DEV, 1'b1}, 1'b0, "R2 read header without command");
        do_stop();

        // R3 / R7: plain read, longer than one byte
        read_tx(8'h10, 5, "R3 plain read");
        read_tx(8'h00, 3, "R3 plain read at zero");

        // R5: crossing the mapped limit
        read_tx(8'hBD, 5, "R5 unmapped tail");

        // R6: no wrap past FFh
        read_tx(8'hFE, 5, "R6 no wrap");

        // R4 / R7: fixed-block commands, reading beyond the count
        read_tx(8'hF3, BLEN + 3, "R4 R7 fixed block F3");
        read_tx(8'hFD, 3, "R4 fixed block FD");
        read_tx(8'hF2, BLEN + 1, "R4 fixed block F2");

        // R8: after NACK, further acknowledges and bytes do nothing
        read_tx(8'h20, 2, "R8 nack read");
        @(negedge clk); mack_valid = 1'b1;
        @(negedge clk); mack_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk(!tx_en, "R8 stays released", tx_en, 0);
        send_byte(8'h55, 1'b0, "R8 idle after nack");

        // R9: STOP in the middle of a read
        do_start();
        send_byte({DEV, 1'b0}, 1'b1, "R9 header");
        send_byte(8'h30, 1'b1, "R9 command");
        do_start();
        send_byte({DEV, 1'b1}, 1'b1, "R9 read header");
        get_byte(exp_at('h30), 1'b0, "R9 first byte");
        quiet = 1'b0;
        repeat (4) @(negedge clk);
        do_stop();
        chk(!tx_en, "R9 stop releases", tx_en, 0);

        // R9: START in the middle of a read restarts as write header
        do_start();
        send_byte({DEV, 1'b0}, 1'b1, "R9 header 2");
        send_byte(8'h40, 1'b1, "R9 command 2");
        do_start();
        send_byte({DEV, 1'b1}, 1'b1, "R9 read header 2");
        get_byte(exp_at('h40), 1'b0, "R9 byte before restart");
        do_start();
        quiet = 1'b1;
        send_byte({DEV, 1'b1}, 1'b0, "R9 read header after abort");
        chk(!tx_en, "R9 abort quiet", tx_en, 0);
        do_stop();

        // recovery after the aborts
        read_tx(8'h41, 2, "R9 R3 recovery read");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule